// File: doc/BRIEF.md
# Wrapped-Order Cache Line Refill Engine

This block refills one cache line of several words after a miss. It captures the miss address and asks memory first for the word the CPU is waiting on. It then requests the other words of the line one at a time, going upward from that word and wrapping past the last word back to word 0. As soon as the first word returns, it is handed to the CPU on a one-cycle restart strobe, so the CPU can continue while the rest of the line is still arriving.

Each returning word is placed in a staging buffer at the slot given by its offset within the line. Once all slots hold data, the whole line and its line address are presented to the cache data array for one cycle. Tag handling and write policy belong to the surrounding cache. The engine keeps at most one memory read outstanding, and it takes no new miss until the current fill has finished.

Top module: `cwf_line_fill`

## Requirements
- R1: When reset is asserted, including in the middle of a fill, `fill_busy`, `mem_rd_en`, `cpu_restart_valid` and `fill_done` are all 0, and the engine returns to idle.
- R2: The first memory read after a miss is accepted goes to the missed word. Its address is the line address of the miss, followed by the 2-bit word offset held in miss address bits [3:2].
- R3: The next three reads go to word offsets k+1, k+2 and k+3, each taken modulo 4, where k is the missed offset.
- R4: `mem_rd_en` is a one-cycle strobe. No new read is issued until `mem_rd_valid` has returned the data for the previous read.
- R5: `cpu_restart_valid` pulses for exactly one cycle per fill. The pulse comes in the cycle after the first memory response, and `cpu_restart_data` then carries that word. With the default configuration, this happens before the line is complete.
- R6: A word returned for offset i is stored in `fill_line_data` bits [32i+31:32i], whatever order it arrived in.
- R7: `fill_done` pulses for exactly one cycle, in the cycle after the fourth response and never earlier. In that cycle, `fill_line_addr` holds miss address bits [31:4] and `fill_line_data` holds the full line.
- R8: `fill_busy` is 1 from the cycle after a miss is accepted through the `fill_done` cycle. A `miss_valid` that arrives while the engine is busy is ignored and does not change the line being filled.
- R9: The byte-offset bits [1:0] of the miss address are ignored. Every memory read address has its two low bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request strobe, taken only when idle |
| miss_addr | input | 32 | Byte address that missed |
| fill_busy | output | 1 | A fill is in progress |
| mem_rd_en | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | 32 | Byte address of the requested word (word aligned) |
| mem_rd_valid | input | 1 | Memory response strobe for the outstanding read |
| mem_rd_data | input | 32 | Memory response word |
| cpu_restart_valid | output | 1 | One-cycle strobe carrying the missed word to the CPU |
| cpu_restart_data | output | 32 | Missed word |
| fill_done | output | 1 | One-cycle line write strobe into the data array |
| fill_line_addr | output | 28 | Line address of the completed line |
| fill_line_data | output | 128 | Completed line, word i in bits [32i+31:32i] |

## Verification
The assertions assume that memory returns exactly one response for each read request, only while that read is outstanding, and never a response that nobody asked for. The bench memory model meets this by waiting to see `mem_rd_en`, letting a per-vector latency of zero to three cycles pass, and then driving `mem_rd_valid` for a single cycle. The bench also raises `miss_valid` during a fill on purpose. It asserts reset in the middle of a fill and withholds the response for that fill, so no response arrives that the engine did not ask for.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_REQ  = 2'd1,
      S_WAIT = 2'd2,
      S_DONE = 2'd3
   } fill_state_e;
endpackage

// File: rtl/cwf_wrap_seq.sv
module cwf_wrap_seq #(
   parameter int OFF_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [OFF_W-1:0] start_off,
   input  logic             step,
   output logic [OFF_W-1:0] cur_off,
   output logic             first,
   output logic             last
);
   logic [OFF_W-1:0] base_q;
   logic [OFF_W-1:0] cnt_q;

   if (OFF_W < 1) begin : g_bad_off
      $error("cwf_wrap_seq: OFF_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         base_q <= start_off;
         cnt_q  <= '0;
      end else if (step) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   // modulo wrap comes from the fixed width of the sum
   assign cur_off = base_q + cnt_q;
   assign first   = (cnt_q == '0);
   assign last    = &cnt_q;

   p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cur_off == $past(start_off)));

   p_wrap_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (cur_off == OFF_W'($past(cur_off) + 1'b1)));
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
   parameter int WORD_W = 32,
   parameter int WORDS  = 4,
   localparam int SLOT_W = $clog2(WORDS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    wr_en,
   input  logic [SLOT_W-1:0]       wr_slot,
   input  logic [WORD_W-1:0]       wr_data,
   output logic [WORDS*WORD_W-1:0] line_data,
   output logic                    all_valid
);
   logic [WORDS-1:0] filled_vec;

   if (WORDS < 2) begin : g_bad_words
      $error("cwf_line_buf: WORDS must be at least 2");
   end

   for (genvar g = 0; g < WORDS; g++) begin : g_slot
      logic [WORD_W-1:0] word_q;
      logic              filled_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q   <= '0;
            filled_q <= 1'b0;
         end else if (clear) begin
            filled_q <= 1'b0;
         end else if (wr_en && (wr_slot == SLOT_W'(g))) begin
            word_q   <= wr_data;
            filled_q <= 1'b1;
         end
      end

      assign line_data[g*WORD_W +: WORD_W] = word_q;
      assign filled_vec[g] = filled_q;
   end

   assign all_valid = &filled_vec;

   // each slot receives exactly one word per fill
   p_slot_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !filled_vec[wr_slot]);
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill
   import cwf_pkg::*;
#(
   parameter int  ADDR_W      = 32,
   parameter int  WORD_W      = 32,
   parameter int  WORDS       = 4,
   parameter bit  RESTART_REG = 1'b1,
   localparam int OFF_W       = $clog2(WORDS),
   localparam int BYTE_W      = $clog2(WORD_W/8),
   localparam int LINE_LSB    = OFF_W + BYTE_W,
   localparam int LINE_W      = ADDR_W - LINE_LSB
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    miss_valid,
   input  logic [ADDR_W-1:0]       miss_addr,
   output logic                    fill_busy,
   output logic                    mem_rd_en,
   output logic [ADDR_W-1:0]       mem_rd_addr,
   input  logic                    mem_rd_valid,
   input  logic [WORD_W-1:0]       mem_rd_data,
   output logic                    cpu_restart_valid,
   output logic [WORD_W-1:0]       cpu_restart_data,
   output logic                    fill_done,
   output logic [LINE_W-1:0]       fill_line_addr,
   output logic [WORDS*WORD_W-1:0] fill_line_data
);
   if ((WORD_W % 8) != 0 || WORD_W < 8) begin : g_bad_word
      $error("cwf_line_fill: WORD_W must be a whole number of bytes");
   end
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("cwf_line_fill: WORDS must be a power of two, at least 2");
   end
   if (ADDR_W <= LINE_LSB) begin : g_bad_addr
      $error("cwf_line_fill: ADDR_W too small for the line size");
   end

   fill_state_e       state_q;
   logic [LINE_W-1:0] line_q;
   logic [OFF_W-1:0]  cur_off;
   logic              seq_first;
   logic              seq_last;
   logic              buf_full;
   logic              accept;
   logic              rsp_take;
   logic              restart_fire;

   assign accept       = (state_q == S_IDLE) && miss_valid;
   assign rsp_take     = (state_q == S_WAIT) && mem_rd_valid;
   assign restart_fire = rsp_take && seq_first;

   cwf_wrap_seq #(.OFF_W(OFF_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .start_off (miss_addr[LINE_LSB-1:BYTE_W]),
      .step      (rsp_take && !seq_last),
      .cur_off   (cur_off),
      .first     (seq_first),
      .last      (seq_last)
   );

   cwf_line_buf #(.WORD_W(WORD_W), .WORDS(WORDS)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (accept),
      .wr_en     (rsp_take),
      .wr_slot   (cur_off),
      .wr_data   (mem_rd_data),
      .line_data (fill_line_data),
      .all_valid (buf_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         line_q  <= '0;
      end else begin
         unique case (state_q)
            S_IDLE: if (accept) begin
               line_q  <= miss_addr[ADDR_W-1:LINE_LSB];
               state_q <= S_REQ;
            end
            S_REQ:  state_q <= S_WAIT;
            S_WAIT: if (rsp_take) state_q <= seq_last ? S_DONE : S_REQ;
            S_DONE: state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign fill_busy      = (state_q != S_IDLE);
   assign mem_rd_en      = (state_q == S_REQ);
   assign mem_rd_addr    = {line_q, cur_off, {BYTE_W{1'b0}}};
   assign fill_done      = (state_q == S_DONE);
   assign fill_line_addr = line_q;

   if (RESTART_REG) begin : g_restart_reg
      logic              rv_q;
      logic [WORD_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rv_q <= 1'b0;
            rd_q <= '0;
         end else begin
            rv_q <= restart_fire;
            if (restart_fire) rd_q <= mem_rd_data;
         end
      end
      assign cpu_restart_valid = rv_q;
      assign cpu_restart_data  = rd_q;
   end else begin : g_restart_comb
      assign cpu_restart_valid = restart_fire;
      assign cpu_restart_data  = mem_rd_data;
   end

   p_rd_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   // input assumption: responses come only for an outstanding read
   p_rsp_expected_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> (state_q == S_WAIT));

   p_restart_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_restart_valid |=> !cpu_restart_valid);

   p_done_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |-> buf_full);

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> !fill_done);

   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_busy && miss_valid) |=> $stable(line_q));

   p_rd_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (mem_rd_addr[BYTE_W-1:0] == '0));
endmodule

// File: tb/tb_cwf_line_fill.sv
module tb_cwf_line_fill;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         miss_valid;
   logic [31:0]  miss_addr;
   logic         fill_busy;
   logic         mem_rd_en;
   logic [31:0]  mem_rd_addr;
   logic         mem_rd_valid;
   logic [31:0]  mem_rd_data;
   logic         cpu_restart_valid;
   logic [31:0]  cpu_restart_data;
   logic         fill_done;
   logic [27:0]  fill_line_addr;
   logic [127:0] fill_line_data;

   int n_chk = 0;
   int n_bad = 0;
   int rtot  = 0;
   int dtot  = 0;
   bit fin   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cwf_line_fill dut (
      .clk               (clk),
      .rst_n             (rst_n),
      .miss_valid        (miss_valid),
      .miss_addr         (miss_addr),
      .fill_busy         (fill_busy),
      .mem_rd_en         (mem_rd_en),
      .mem_rd_addr       (mem_rd_addr),
      .mem_rd_valid      (mem_rd_valid),
      .mem_rd_data       (mem_rd_data),
      .cpu_restart_valid (cpu_restart_valid),
      .cpu_restart_data  (cpu_restart_data),
      .fill_done         (fill_done),
      .fill_line_addr    (fill_line_addr),
      .fill_line_data    (fill_line_data)
   );

   // vector: {miss address, response latency}
   localparam logic [35:0] VEC [8] = '{
      {32'h0000_1000, 4'd0},
      {32'h0000_2014, 4'd1},
      {32'h8000_302B, 4'd2},
      {32'hFFFF_FFFF, 4'd0},
      {32'h1234_5676, 4'd3},
      {32'hDEAD_BEE8, 4'd1},
      {32'h0F0F_0F0C, 4'd0},
      {32'h0000_0001, 4'd2}
   };

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return (a * 32'h0100_0193) ^ 32'hC3A5_5A3C;
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   initial forever begin
      @(negedge clk);
      if (cpu_restart_valid) rtot++;
      if (fill_done) dtot++;
   end

   task automatic run_fill(input logic [31:0] a, input int lat, input bit intrude);
      logic [27:0]  ln;
      logic [1:0]   off;
      logic [31:0]  ea;
      logic [127:0] el;
      int r0;
      int d0;
      ln = a[31:4];
      off = a[3:2];
      r0 = rtot;
      d0 = dtot;
      @(negedge clk);
      miss_valid = 1'b1;
      miss_addr  = a;
      @(negedge clk);
      miss_valid = 1'b0;
      chk(fill_busy == 1'b1, "R8 busy after accept", fill_busy, 1);
      for (int k = 0; k < 4; k++) begin
         for (int w = 0; w < 20 && !mem_rd_en; w++) @(negedge clk);
         ea = {ln, 2'(off + 2'(k)), 2'b00};
         chk(mem_rd_en && mem_rd_addr == ea,
             (k == 0) ? "R2 R9 first read address" : "R3 R9 wrapped read address",
             mem_rd_addr, ea);
         @(negedge clk);
         chk(!mem_rd_en, "R4 single outstanding read", mem_rd_en, 0);
         for (int l = 0; l < lat; l++) begin
            @(negedge clk);
            chk(!mem_rd_en, "R4 no read while waiting", mem_rd_en, 0);
         end
         mem_rd_valid = 1'b1;
         mem_rd_data  = mem_word(ea);
         if (intrude) begin
            miss_valid = 1'b1;
            miss_addr  = ~a;
         end
         @(negedge clk);
         mem_rd_valid = 1'b0;
         mem_rd_data  = '0;
         miss_valid   = 1'b0;
         if (k == 0)
            chk(cpu_restart_valid && cpu_restart_data == mem_word(ea),
                "R5 early restart word", {cpu_restart_valid, cpu_restart_data},
                {1'b1, mem_word(ea)});
         chk(fill_done == (k == 3), "R7 done timing", fill_done, (k == 3));
         if (k == 3) begin
            el = {mem_word({ln, 2'd3, 2'd0}), mem_word({ln, 2'd2, 2'd0}),
                  mem_word({ln, 2'd1, 2'd0}), mem_word({ln, 2'd0, 2'd0})};
            chk(fill_line_addr == ln, "R7 R8 line address", fill_line_addr, ln);
            chk(fill_line_data == el, "R6 slot placement", fill_line_data, el);
         end
      end
      @(negedge clk);
      chk(!fill_done && !fill_busy, "R7 done ends, idle", {fill_done, fill_busy}, 0);
      chk(rtot - r0 == 1, "R5 single restart pulse", rtot - r0, 1);
      chk(dtot - d0 == 1, "R7 single done pulse", dtot - d0, 1);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!fin) begin
         n_bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n        = 1'b0;
      miss_valid   = 1'b0;
      miss_addr    = '0;
      mem_rd_valid = 1'b0;
      mem_rd_data  = '0;
      repeat (3) @(negedge clk);
      chk({fill_busy, mem_rd_en, cpu_restart_valid, fill_done} == 4'b0,
          "R1 reset outputs", {fill_busy, mem_rd_en, cpu_restart_valid, fill_done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!fill_busy && !mem_rd_en, "R1 idle after reset", {fill_busy, mem_rd_en}, 0);

      for (int i = 0; i < 8; i++)
         run_fill(VEC[i][35:4], int'(VEC[i][3:0]), 1'b0);

      // misses raised during a fill are ignored (R8)
      run_fill(32'h4567_89A8, 1, 1'b1);
      run_fill(32'h0000_00F4, 0, 1'b1);

      // reset in the middle of a fill (R1)
      @(negedge clk);
      miss_valid = 1'b1;
      miss_addr  = 32'h0000_5558;
      @(negedge clk);
      miss_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk({fill_busy, mem_rd_en, cpu_restart_valid, fill_done} == 4'b0,
          "R1 mid-fill reset", {fill_busy, mem_rd_en, cpu_restart_valid, fill_done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!fill_busy, "R1 idle after mid-fill reset", fill_busy, 0);
      run_fill(32'h0000_555C, 2, 1'b0);

      fin = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule